// File: doc/BRIEF.md
# Accumulator Processor with Hardwired Sequencer

This block is a small stored-program processor. It holds its working value in a 12-bit accumulator and steps through a program with an 8-bit program counter. Instructions and data share one memory. The processor reaches that memory through an address register that drives the address pins and a data register that captures read data. A 4-bit instruction register keeps the opcode of the instruction in flight.

After reset the processor sits idle. A one-cycle `start` pulse clears the program counter and the address register, and execution begins at word 0. From then on a hardwired state machine runs each instruction through a fixed chain of states: fetch, effective-address generation, an optional taken-branch cycle, operand access and execute. Each instruction type therefore has a known cycle count. The fetch cycle advances the program counter and the address register together, so the next fetch address is already in place when the instruction finishes. The memory read path is combinational: read data must be valid in the same cycle that `mem_rd` is high.

Top module: `acc_cpu`

## Requirements
- R1: After a synchronous active-low reset, the processor is idle. `mem_rd` and `mem_wr` are 0, `mem_addr` is 0 and `mem_wdata` (the accumulator) is 0. It stays idle, with no memory access, until `start` is sampled high.
- R2: When `start` is sampled high while idle, the program counter and address register are cleared, and the next cycle fetches the word at address 0.
- R3: An instruction word carries its opcode in bits 11:8 and its operand address in bits 7:0. The fetch cycle reads the word at the program counter with `mem_rd`=1 and advances the program counter by one.
- R4: JMP (opcode 0000) loads the program counter with the operand address and takes 2 cycles.
- R5: JN (opcode 0001) branches when accumulator bit 11 is 1 and then takes 3 cycles. Otherwise it takes 2 cycles and execution continues at the next word.
- R6: JZ (opcode 0010) branches when all 12 accumulator bits are 0 and then takes 3 cycles. Otherwise it takes 2 cycles and execution continues at the next word.
- R7: LOAD (opcode 0100) copies the memory word at the operand address into the accumulator and takes 4 cycles.
- R8: STORE (opcode 0101) takes 3 cycles. In its third cycle it drives `mem_wr`=1, with the operand address on `mem_addr` and the accumulator on `mem_wdata`.
- R9: AND (opcode 1000) and OR (opcode 1001) combine the accumulator bitwise with the memory word at the operand address, write the result to the accumulator and take 4 cycles each.
- R10: ADD (opcode 1010) and SUB (opcode 1011) work in 12-bit two's complement and wrap modulo 4096. For example, 7 minus 10 gives FFDh and FFDh plus 3 gives 000h. Each takes 4 cycles.
- R11: Every other opcode is a no-op. It takes 2 cycles and leaves the accumulator unchanged.
- R12: `mem_rd` and `mem_wr` are never 1 in the same cycle, and `mem_wr` is 1 only in the write cycle of a STORE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins execution at address 0 when sampled high while idle |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_rdata | input | 12 | Read data, valid in the same cycle as `mem_rd` |
| mem_wdata | output | 12 | Write data, always the accumulator |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
The bench times every store from the start pulse, so a wrong cycle count in any instruction type moves a write to the wrong cycle and is reported. The branches are driven both ways on an accumulator that is negative, zero and positive. Skipped words hold stores to a guard address: a JN or JZ that decides wrongly, or a taken branch that misses its extra cycle, writes there or shifts a store's timing. A sum that wraps to zero feeds a JZ, and a subtraction that goes below zero is stored. This catches an adder that keeps a carry, or a zero test read from the ALU output instead of the accumulator. A reserved opcode between two stores of the same value shows whether a no-op disturbs the accumulator or takes the wrong number of cycles.

// File: rtl/acc_pkg.sv
// Package: shared opcode constants, sequencer states and the control bundle
// passed from the sequencer to the datapath of the accumulator processor.
package acc_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_JMP   = 4'b0000;
    localparam logic [OP_W-1:0] OPC_JN    = 4'b0001;
    localparam logic [OP_W-1:0] OPC_JZ    = 4'b0010;
    localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0100;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0101;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'b1011;

    // Opcodes whose upper two bits are 10 belong to the ALU group.
    localparam logic [1:0] ALU_GROUP = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EAGEN,
        ST_BTAKEN,
        ST_OPACC,
        ST_EXEC
    } seq_state_t;

    // One-cycle register-transfer enables issued by the sequencer.
    typedef struct packed {
        logic clr;     // clear PC and MAR
        logic fetch;   // capture instruction, PC and MAR <= PC+1
        logic jump;    // PC and MAR <= operand address
        logic mar_ea;  // MAR <= operand address
        logic mar_pc;  // MAR <= PC
        logic mdr_ld;  // MDR <= read data
        logic acc_ld;  // accumulator <= execute result
        logic rd;      // memory read strobe
        logic wr;      // memory write strobe
    } ctl_t;

endpackage

// File: rtl/acc_alu.sv
// Module: acc_alu
// Purely combinational 12-bit operation unit for the ALU opcode group.
// The low two opcode bits pick AND, OR, ADD or SUB. Arithmetic wraps modulo
// 2**DW. Assumes the caller only uses the result for ALU-group opcodes.
module acc_alu #(
    parameter int DW = 12
) (
    input  logic [1:0]    op,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] res
);

    // Select the operation named by the low opcode bits.
    always_comb begin
        unique case (op)
            2'b00:   res = lhs & rhs;
            2'b01:   res = lhs | rhs;
            2'b10:   res = lhs + rhs;
            default: res = lhs - rhs;
        endcase
    end

endmodule

// File: rtl/acc_seq.sv
// Module: acc_seq
// Hardwired sequencer. It holds the state register and decodes the control
// bundle for the current state from the opcode and the accumulator flags.
// Assumes the flags come from a zero/sign test that does not use the ALU.
module acc_seq
    import acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] opc,
    input  logic            acc_neg,
    input  logic            acc_zero,
    output ctl_t            ctl
);

    seq_state_t state, state_nx;
    logic       is_mem_op;

    assign is_mem_op = (opc[OP_W-1 -: 2] == ALU_GROUP) ||
                       (opc == OPC_LOAD) || (opc == OPC_STORE);

    // Next-state and control decode for the current state.
    always_comb begin
        ctl      = '0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ctl.clr  = 1'b1;
                    state_nx = ST_FETCH;
                end
            end
            ST_FETCH: begin
                ctl.rd    = 1'b1;
                ctl.fetch = 1'b1;
                state_nx  = ST_EAGEN;
            end
            ST_EAGEN: begin
                state_nx = ST_FETCH;
                if (opc == OPC_JMP) begin
                    ctl.jump = 1'b1;
                end else if ((opc == OPC_JN && acc_neg) || (opc == OPC_JZ && acc_zero)) begin
                    state_nx = ST_BTAKEN;
                end else if (is_mem_op) begin
                    ctl.mar_ea = 1'b1;
                    state_nx   = ST_OPACC;
                end
            end
            ST_BTAKEN: begin
                ctl.jump = 1'b1;
                state_nx = ST_FETCH;
            end
            ST_OPACC: begin
                ctl.mar_pc = 1'b1;
                if (opc == OPC_STORE) begin
                    ctl.wr   = 1'b1;
                    state_nx = ST_FETCH;
                end else begin
                    ctl.rd     = 1'b1;
                    ctl.mdr_ld = 1'b1;
                    state_nx   = ST_EXEC;
                end
            end
            default: begin
                ctl.acc_ld = 1'b1;
                state_nx   = ST_FETCH;
            end
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R12: the read and write strobes never overlap
    p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.rd && ctl.wr));

    // R1: an idle machine touches no memory
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ctl.rd && !ctl.wr));

    // R3: every fetch is followed by address generation
    p_fetch_then_ea_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_EAGEN));

    // R11: an opcode outside the defined set goes straight back to fetch
    p_reserved_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EAGEN && !is_mem_op && opc != OPC_JMP &&
         opc != OPC_JN && opc != OPC_JZ) |=> (state == ST_FETCH));

    // R8: a write happens only in operand access of a store
    p_write_only_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr |-> (state == ST_OPACC && opc == OPC_STORE));

endmodule

// File: rtl/acc_datapath.sv
// Module: acc_datapath
// Register file of the processor: PC, MAR, MDR, IR and accumulator. It also
// holds the sign/zero test beside the ALU. Each register moves only on the
// sequencer's enables, and the sequencer never raises conflicting enables
// in one cycle.
module acc_datapath
    import acc_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = OP_W + AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_t            ctl,
    input  logic [DW-1:0]   rdata,
    output logic [AW-1:0]   mar,
    output logic [DW-1:0]   acc,
    output logic [OP_W-1:0] ir,
    output logic            acc_neg,
    output logic            acc_zero
);

    logic [AW-1:0] pc;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] ea;
    logic [DW-1:0] mdr;
    logic [DW-1:0] alu_res;

    assign pc_inc   = pc + 1'b1;
    assign ea       = mdr[AW-1:0];
    assign acc_neg  = acc[DW-1];
    assign acc_zero = (acc == '0);

    acc_alu #(.DW(DW)) u_alu (
        .op  (ir[1:0]),
        .lhs (acc),
        .rhs (mdr),
        .res (alu_res)
    );

    // Program counter: cleared on start, stepped on fetch, loaded on jumps.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.clr) pc <= '0;
        else if (ctl.fetch)    pc <= pc_inc;
        else if (ctl.jump)     pc <= ea;
    end

    // Address register: follows PC on fetch/jump, else operand or PC.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl.clr) mar <= '0;
        else if (ctl.fetch)    mar <= pc_inc;
        else if (ctl.jump)     mar <= ea;
        else if (ctl.mar_ea)   mar <= ea;
        else if (ctl.mar_pc)   mar <= pc;
    end

    // Data and instruction registers: capture read data when told to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.fetch || ctl.mdr_ld) mdr <= rdata;
            if (ctl.fetch)               ir  <= rdata[DW-1 -: OP_W];
        end
    end

    // Accumulator: takes the operand for LOAD, the ALU result otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc <= '0;
        else if (ctl.acc_ld) acc <= (ir == OPC_LOAD) ? mdr : alu_res;
    end

    // R3: fetch advances PC by one and points MAR at the new PC
    p_fetch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.fetch |=> (pc == AW'($past(pc) + 1'b1)) && (mar == pc));

    // R4: a jump puts the operand address into both PC and MAR
    p_jump_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> (pc == $past(mdr[AW-1:0])) && (mar == pc));

    // R10: subtraction wraps in two's complement
    p_sub_wraps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.acc_ld && ir == OPC_SUB) |=> (acc == DW'($past(acc) - $past(mdr))));

    // R2: start clears PC and MAR together
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr |=> (pc == '0) && (mar == '0));

endmodule

// File: rtl/acc_cpu.sv
// Module: acc_cpu
// Top of the accumulator processor: wires the sequencer to the datapath and
// exposes the single shared memory port. Assumes memory read data is valid
// in the same cycle as mem_rd (combinational read).
module acc_cpu
    import acc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic [AW-1:0]       mem_addr,
    input  logic [OP_W+AW-1:0]  mem_rdata,
    output logic [OP_W+AW-1:0]  mem_wdata,
    output logic                mem_rd,
    output logic                mem_wr
);

    localparam int DW = OP_W + AW;

    ctl_t            ctl;
    logic [OP_W-1:0] ir;
    logic            acc_neg;
    logic            acc_zero;

    acc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .opc      (ir),
        .acc_neg  (acc_neg),
        .acc_zero (acc_zero),
        .ctl      (ctl)
    );

    acc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .rdata    (mem_rdata),
        .mar      (mem_addr),
        .acc      (mem_wdata),
        .ir       (ir),
        .acc_neg  (acc_neg),
        .acc_zero (acc_zero)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;

endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: programs are loaded into a model memory, the expected
// stores (address, data, cycle after start) are queued, and a monitor pops
// and compares them as the processor writes.
module acc_cpu_bench;

    typedef struct {
        logic [7:0]  addr;
        logic [11:0] data;
        int          cyc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  mem_addr;
    logic [11:0] mem_rdata;
    logic [11:0] mem_wdata;
    logic        mem_rd;
    logic        mem_wr;

    logic [11:0] mem [256];
    exp_t        exp_q [$];
    int          cyc = 0;
    int          n_tests = 0;
    int          n_fail = 0;
    int          rw_bad = 0;
    int          wd = 0;

    always #2 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    assign mem_rdata = mem[mem_addr];

    // Model memory write port and the cycle counter relative to start.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (start) cyc <= 0;
        else       cyc <= cyc + 1;
        wd <= wd + 1;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (wd > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 20000", wd);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Monitor: pop and compare every store seen on the memory port.
    always @(negedge clk) begin
        if (rst_n && mem_rd && mem_wr) rw_bad++;
        if (rst_n && mem_wr) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected write: actual addr %h data %h cyc %0d, expected none",
                         mem_addr, mem_wdata, cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (mem_addr !== e.addr || mem_wdata !== e.data || cyc != e.cyc) begin
                    n_fail++;
                    $display("FAIL %s store: actual addr %h data %h cyc %0d, expected addr %h data %h cyc %0d",
                             e.tag, mem_addr, mem_wdata, cyc, e.addr, e.data, e.cyc);
                end
            end
        end
    end

    task automatic push_exp(input logic [7:0] a, input logic [11:0] d, input int c, input string t);
        exp_t e;
        e.addr = a; e.data = d; e.cyc = c; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h, expected %h", tag, act, expv);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 12'h000;
    endtask

    // Reset, check the idle state, then pulse start.
    task automatic reset_and_start();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state on the ports
        check(mem_rd == 1'b0 && mem_wr == 1'b0, "R1 strobes after reset", {mem_rd, mem_wr}, 0);
        check(mem_addr == 8'h00, "R1 address after reset", mem_addr, 0);
        check(mem_wdata == 12'h000, "R1 accumulator after reset", mem_wdata, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr) seen++;
            end
            check(seen == 0, "R1 idle without start", seen, 0);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first fetch reads address 0
        check(mem_rd == 1'b1 && mem_addr == 8'h00, "R2 first fetch at 0", {mem_rd, mem_addr}, 12'h100);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        repeat (10) @(negedge clk);
        // R5 / R6: skipped words held stores to the guard address 43h
        check(mem[8'h43] == 12'h000, "R5 R6 skipped words not run", mem[8'h43], 0);
    endtask

    initial begin
        // Program A: subtraction, taken JN, wrapping ADD, taken JZ,
        // LOAD/OR/AND, untaken branches, reserved opcode, JMP.
        clear_mem();
        mem[8'h00] = 12'h430; mem[8'h01] = 12'hB31; mem[8'h02] = 12'h540;
        mem[8'h03] = 12'h106; mem[8'h04] = 12'h543; mem[8'h05] = 12'h543;
        mem[8'h06] = 12'hA32; mem[8'h07] = 12'h20A; mem[8'h08] = 12'h543;
        mem[8'h09] = 12'h543; mem[8'h0A] = 12'h434; mem[8'h0B] = 12'h935;
        mem[8'h0C] = 12'h836; mem[8'h0D] = 12'h541; mem[8'h0E] = 12'h100;
        mem[8'h0F] = 12'h200; mem[8'h10] = 12'h3FF; mem[8'h11] = 12'h542;
        mem[8'h12] = 12'h014; mem[8'h13] = 12'h543; mem[8'h14] = 12'h544;
        mem[8'h15] = 12'h015;
        mem[8'h30] = 12'h007; mem[8'h31] = 12'h00A; mem[8'h32] = 12'h003;
        mem[8'h34] = 12'h0F0; mem[8'h35] = 12'h00F; mem[8'h36] = 12'h03C;
        push_exp(8'h40, 12'hFFD, 10, "R10 sub wraps, R7 load 4 cycles");
        push_exp(8'h41, 12'h03C, 35, "R9 and/or, R5 R6 taken 3 cycles");
        push_exp(8'h42, 12'h03C, 44, "R11 reserved no-op, untaken 2 cycles");
        push_exp(8'h44, 12'h03C, 49, "R4 jmp 2 cycles, R8 store");
        reset_and_start();
        drain("R3 program A stores all seen");

        // Program B: negative load, untaken JZ, taken JN, SUB to positive,
        // untaken JN.
        clear_mem();
        mem[8'h00] = 12'h430; mem[8'h01] = 12'h205; mem[8'h02] = 12'h105;
        mem[8'h03] = 12'h543; mem[8'h04] = 12'h543; mem[8'h05] = 12'h531;
        mem[8'h06] = 12'hB32; mem[8'h07] = 12'h100; mem[8'h08] = 12'h533;
        mem[8'h09] = 12'h009;
        mem[8'h30] = 12'h800; mem[8'h32] = 12'h001;
        push_exp(8'h31, 12'h800, 11, "R6 jz untaken on nonzero, R5 jn taken");
        push_exp(8'h33, 12'h7FF, 20, "R10 sub to 7FF, R5 jn untaken");
        reset_and_start();
        drain("R3 program B stores all seen");

        check(rw_bad == 0, "R12 strobes never overlap", rw_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule